// File: doc/BRIEF.md
# Drive Level Adjust Resolver

This block turns the per-lane drive adjustment requests that a DisplayPort sink reports during link training into one common setting, which is then sent back to every active lane. Each lane supplies a 2-bit voltage-swing request and a 2-bit pre-emphasis request. The block keeps only the lanes that the active lane count enables. It takes the worst case of each request over those lanes. It then limits the swing to level 2, and caps pre-emphasis with a limit that falls as the swing rises.

The result is four lane training bytes in the usual lane-set layout. Swing sits in bits 1:0 and its "maximum reached" flag in bit 2. Pre-emphasis sits in bits 4:3 and its "maximum reached" flag in bit 5. Bits 7:6 are zero. A summary flag tells the training sequencer that every active lane has hit the swing limit, which is the signal to stop raising the swing. By default the outputs are registered, so a result appears one clock after its inputs. A parameter removes the register for a purely combinational path.

Top module: `drv_adj_resolver`

## Requirements
- R1: The swing field equals the largest swing request among active lanes; requests on inactive lanes have no effect on it.
- R2: The pre-emphasis field comes from the largest pre-emphasis request among active lanes; requests on inactive lanes have no effect on it.
- R3: When the chosen swing is 2 or 3, the swing field is 2 and bit 2 is set; otherwise the field equals the chosen swing and bit 2 is clear.
- R4: The pre-emphasis ceiling is set by the final swing field: swing 0 allows 3, swing 1 allows 2, swing 2 allows 1, any higher swing allows 0.
- R5: When the chosen pre-emphasis is at or above the ceiling, the pre-emphasis field (bits 4:3) equals the ceiling and bit 5 is set; otherwise the field equals the chosen value and bit 5 is clear.
- R6: Every active lane carries the identical byte, and bits 7:6 of every byte are zero.
- R7: Lane k is active exactly when k is less than `lane_cnt`, with counts above the lane total treated as all lanes. Bytes of inactive lanes are zero. Lane k occupies bits 8k+7:8k of `lane_set`.
- R8: `all_max_swing` is 1 only when at least one lane is active and every active lane byte has bit 2 set; with `lane_cnt` 0 it is 0.
- R9: While `rst_n` is low, and on the cycle after `clear` is sampled high, all bytes are zero and `all_max_swing` is 0, whatever the requests.
- R10: With the output register present (default), the outputs reflect the inputs sampled at the preceding rising clock edge, so a new input set appears every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous request to zero all outputs |
| lane_cnt | input | 3 | Number of active lanes (lanes 0 .. lane_cnt-1) |
| swing_req | input | 8 | Swing request, lane k in bits 2k+1:2k |
| emph_req | input | 8 | Pre-emphasis request, lane k in bits 2k+1:2k |
| lane_set | output | 32 | Training byte per lane, lane k in bits 8k+7:8k |
| all_max_swing | output | 1 | Every active lane is at the swing limit |

## Verification
Every lane byte and the summary flag come from a single register stage. A request set driven after one falling edge is therefore due one rising edge later, and so is a `clear`. The driver applies one request set per falling edge and queues its expected outputs. The monitor removes one entry per cycle, 2 ns after the next rising edge. This keeps each comparison exactly one cycle behind its stimulus, including back-to-back changes. The reset state is checked on its own, before the first stimulus enters the queue.

// File: rtl/drv_adj_pkg.sv
package drv_adj_pkg;
  localparam int LVL_W  = 2;
  localparam int BYTE_W = 8;

  typedef logic [LVL_W-1:0] lvl_t;

  // lane training byte, MSB first
  typedef struct packed {
    logic [1:0] rsvd;       // 7:6
    logic       emph_max;   // 5
    lvl_t       emph;       // 4:3
    logic       swing_max;  // 2
    lvl_t       swing;      // 1:0
  } lane_byte_t;

  localparam lvl_t SWING_LIMIT = 2'd2;

  function automatic lvl_t max_lvl(input lvl_t a, input lvl_t b);
    return (a > b) ? a : b;
  endfunction

  // pre-emphasis allowed for a given final swing
  function automatic lvl_t emph_ceiling(input lvl_t swing);
    case (swing)
      2'd0:    return 2'd3;
      2'd1:    return 2'd2;
      2'd2:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/dal_lane_mask.sv
module dal_lane_mask #(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = $clog2(NUM_LANES + 1)
) (
  input  logic [CNT_W-1:0]     lane_cnt,
  output logic [NUM_LANES-1:0] lane_active
);
  // counts above NUM_LANES simply enable every lane
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    assign lane_active[k] = (int'(lane_cnt) > k);
  end
endmodule

// File: rtl/dal_req_reduce.sv
module dal_req_reduce
  import drv_adj_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic [NUM_LANES-1:0]       lane_active,
  input  logic [NUM_LANES*LVL_W-1:0] req_flat,
  output lvl_t                       req_max
);
  always_comb begin
    req_max = '0;
    for (int k = 0; k < NUM_LANES; k++) begin
      if (lane_active[k]) req_max = max_lvl(req_max, req_flat[LVL_W*k +: LVL_W]);
    end
  end
endmodule

// File: rtl/dal_level_clamp.sv
module dal_level_clamp
  import drv_adj_pkg::*;
(
  input  lvl_t       swing_pick,
  input  lvl_t       emph_pick,
  output lane_byte_t common_byte,
  output logic       swing_sat,
  output logic       emph_sat
);
  lvl_t swing_fin;
  lvl_t ceil_lvl;

  always_comb begin
    swing_sat = (swing_pick >= SWING_LIMIT);
    swing_fin = swing_sat ? SWING_LIMIT : swing_pick;
    ceil_lvl  = emph_ceiling(swing_fin);
    emph_sat  = (emph_pick >= ceil_lvl);

    common_byte           = '0;
    common_byte.swing     = swing_fin;
    common_byte.swing_max = swing_sat;
    common_byte.emph      = emph_sat ? ceil_lvl : emph_pick;
    common_byte.emph_max  = emph_sat;
  end
endmodule

// File: rtl/dal_out_stage.sv
module dal_out_stage #(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] set_d,
  input  logic         flag_d,
  output logic [W-1:0] set_q,
  output logic         flag_q
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        set_q  <= '0;
        flag_q <= 1'b0;
      end else if (clear) begin
        set_q  <= '0;
        flag_q <= 1'b0;
      end else begin
        set_q  <= set_d;
        flag_q <= flag_d;
      end
    end
  end else begin : g_comb
    logic live;
    assign live   = rst_n && !clear;
    assign set_q  = live ? set_d : '0;
    assign flag_q = live && flag_d;
  end
endmodule

// File: rtl/drv_adj_resolver.sv
module drv_adj_resolver
  import drv_adj_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter bit REG_OUT   = 1'b1,
  localparam int CNT_W    = $clog2(NUM_LANES + 1),
  localparam int SET_W    = NUM_LANES * BYTE_W,
  localparam int REQ_W    = NUM_LANES * LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] lane_cnt,
  input  logic [REQ_W-1:0] swing_req,
  input  logic [REQ_W-1:0] emph_req,
  output logic [SET_W-1:0] lane_set,
  output logic             all_max_swing
);
  logic [NUM_LANES-1:0] lane_active;
  lvl_t                 swing_pick;
  lvl_t                 emph_pick;
  lane_byte_t           common_byte;
  logic                 swing_sat;
  logic                 emph_sat;
  logic [SET_W-1:0]     lane_set_d;
  logic [NUM_LANES-1:0] lane_at_max;
  logic                 all_max_d;

  dal_lane_mask #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_mask (
    .lane_cnt    (lane_cnt),
    .lane_active (lane_active)
  );

  dal_req_reduce #(.NUM_LANES(NUM_LANES)) u_swing_max (
    .lane_active (lane_active),
    .req_flat    (swing_req),
    .req_max     (swing_pick)
  );

  dal_req_reduce #(.NUM_LANES(NUM_LANES)) u_emph_max (
    .lane_active (lane_active),
    .req_flat    (emph_req),
    .req_max     (emph_pick)
  );

  dal_level_clamp u_clamp (
    .swing_pick  (swing_pick),
    .emph_pick   (emph_pick),
    .common_byte (common_byte),
    .swing_sat   (swing_sat),
    .emph_sat    (emph_sat)
  );

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_fan
    lane_byte_t lane_b;
    assign lane_b                          = lane_active[k] ? common_byte : '0;
    assign lane_set_d[BYTE_W*k +: BYTE_W]  = lane_b;
    assign lane_at_max[k]                  = ~lane_active[k] | lane_b.swing_max;
  end

  assign all_max_d = (|lane_active) && (&lane_at_max);

  dal_out_stage #(.W(SET_W), .REG_OUT(REG_OUT)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .set_d  (lane_set_d),
    .flag_d (all_max_d),
    .set_q  (lane_set),
    .flag_q (all_max_swing)
  );

  // emph_sat is carried in the byte; keep the named wire visible
  logic emph_sat_seen;
  assign emph_sat_seen = emph_sat;
endmodule

// File: rtl/drv_adj_resolver_chk.sv
module drv_adj_resolver_chk #(
  parameter int NUM_LANES = 4,
  parameter bit REG_OUT   = 1'b1,
  localparam int CNT_W    = $clog2(NUM_LANES + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clear,
  input logic [CNT_W-1:0]        lane_cnt,
  input logic [NUM_LANES*8-1:0]  lane_set,
  input logic                    all_max_swing
);
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    logic [7:0] b;
    assign b = lane_set[8*k +: 8];

    AST_SWING_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      b[1:0] != 2'd3); // R3
    AST_SWING_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      b[2] == (b[1:0] == 2'd2)); // R3
    AST_EMPH_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, b[4:3]} + {1'b0, b[1:0]}) <= 3'd3); // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      b[7:6] == 2'b00); // R6
    AST_SAME_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (b != 8'd0) |-> (b == lane_set[7:0])); // R6

    if (REG_OUT) begin : g_seq
      AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lane_cnt) <= k) |=> (b == 8'd0)); // R7
    end
  end

  AST_FLAG_NEEDS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    all_max_swing |-> lane_set[2]); // R8

  if (REG_OUT) begin : g_clr
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (lane_set == '0 && !all_max_swing)); // R9
  end
endmodule

bind drv_adj_resolver drv_adj_resolver_chk #(
  .NUM_LANES (NUM_LANES),
  .REG_OUT   (REG_OUT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clear         (clear),
  .lane_cnt      (lane_cnt),
  .lane_set      (lane_set),
  .all_max_swing (all_max_swing)
);

// File: tb/drv_adj_resolver_test.sv
`timescale 1ns/1ps
module drv_adj_resolver_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic [2:0]  lane_cnt = '0;
  logic [7:0]  swing_req = '0;
  logic [7:0]  emph_req = '0;
  logic [31:0] lane_set;
  logic        all_max_swing;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] exp_set;
    logic        exp_flag;
    string       tag;
  } exp_item_t;
  exp_item_t sb_q[$];

  always #2.5 clk = ~clk;

  drv_adj_resolver uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear         (clear),
    .lane_cnt      (lane_cnt),
    .swing_req     (swing_req),
    .emph_req      (emph_req),
    .lane_set      (lane_set),
    .all_max_swing (all_max_swing)
  );

  // independent reference: ceiling written as 3 - swing over the reachable range
  function automatic exp_item_t model(input logic [2:0] c, input logic [7:0] s,
                                      input logic [7:0] e, input logic clr, input string tag);
    exp_item_t it;
    int n, ms, me, sw, em, ceil;
    bit sf, ef;
    logic [7:0] byte_v;
    it.tag = tag;
    it.exp_set = '0;
    it.exp_flag = 1'b0;
    if (clr) return it;
    n = (c > 4) ? 4 : int'(c);
    ms = 0; me = 0;
    for (int i = 0; i < n; i++) begin
      if (int'(s[2*i +: 2]) > ms) ms = int'(s[2*i +: 2]);
      if (int'(e[2*i +: 2]) > me) me = int'(e[2*i +: 2]);
    end
    sf = (ms > 1);
    sw = sf ? 2 : ms;
    ceil = 3 - sw;
    ef = (me >= ceil);
    em = ef ? ceil : me;
    byte_v = {2'b00, ef, em[1:0], sf, sw[1:0]};
    for (int i = 0; i < n; i++) it.exp_set[8*i +: 8] = byte_v;
    it.exp_flag = (n > 0) && sf;
    return it;
  endfunction

  task automatic apply(input logic [2:0] c, input logic [7:0] s, input logic [7:0] e,
                       input logic clr, input string tag);
    @(negedge clk);
    lane_cnt  = c;
    swing_req = s;
    emph_req  = e;
    clear     = clr;
    sb_q.push_back(model(c, s, e, clr, tag));
  endtask

  task automatic print_summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // monitor: result due one rising edge after the driving falling edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      compared++;
      if (lane_set !== it.exp_set || all_max_swing !== it.exp_flag) begin
        mismatched++;
        $display("FAIL %s: lane_set=%h flag=%b expected lane_set=%h flag=%b",
                 it.tag, lane_set, all_max_swing, it.exp_set, it.exp_flag);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    print_summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (lane_set !== '0 || all_max_swing !== 1'b0) begin
      mismatched++;
      $display("FAIL R9 reset: lane_set=%h flag=%b expected 0 / 0", lane_set, all_max_swing);
    end
    rst_n = 1'b1;

    apply(3'd4, {2'd0, 2'd0, 2'd1, 2'd0}, 8'h00, 0, "R1 max over four lanes");
    apply(3'd1, {2'd0, 2'd0, 2'd3, 2'd0}, 8'h00, 0, "R1 inactive swing ignored");
    apply(3'd2, {2'd0, 2'd0, 2'd3, 2'd0}, 8'h00, 0, "R3 swing clamp and R8 flag");
    apply(3'd4, 8'h00, {2'd0, 2'd3, 2'd0, 2'd0}, 0, "R4 swing0 ceiling 3, R5");
    apply(3'd4, {2'd1, 2'd0, 2'd0, 2'd0}, {2'd3, 2'd0, 2'd0, 2'd0}, 0, "R4 swing1 ceiling 2");
    apply(3'd4, {2'd1, 2'd0, 2'd0, 2'd0}, {2'd0, 2'd0, 2'd0, 2'd1}, 0, "R5 below ceiling");
    apply(3'd4, {2'd0, 2'd2, 2'd0, 2'd0}, {2'd0, 2'd0, 2'd1, 2'd0}, 0, "R4 swing2 ceiling 1");
    apply(3'd2, 8'h00, {2'd3, 2'd0, 2'd0, 2'd1}, 0, "R2 inactive emphasis ignored");
    apply(3'd3, {2'd3, 2'd0, 2'd1, 2'd0}, {2'd0, 2'd0, 2'd1, 2'd0}, 0, "R7 three lanes, lane3 zero");
    apply(3'd0, 8'hFF, 8'hFF, 0, "R8 no lanes, flag low");
    apply(3'd7, {2'd0, 2'd0, 2'd0, 2'd2}, 8'h00, 0, "R7 count clamped to all lanes");
    apply(3'd4, 8'hFF, 8'hFF, 1, "R9 clear zeroes outputs");
    apply(3'd4, 8'hFF, 8'h00, 0, "R10 back-to-back A");
    apply(3'd2, 8'h00, 8'h05, 0, "R10 back-to-back B");
    apply(3'd4, 8'h55, 8'hAA, 0, "R6 identical bytes");
    apply(3'd1, 8'h02, 8'h03, 0, "R3 single lane clamp");

    @(negedge clk);
    clear = 1'b0;
    while (sb_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    print_summary();
  end
endmodule